// File: doc/BRIEF.md
# Dual-Select Byte-Wide Static RAM

This block is a synthesizable model of a discrete byte-wide static RAM as it sits on a small microcontroller bus. It stores 8192 bytes behind a 13-bit address. The data path is split into a data-in bus, a data-out bus and an output-drive flag, so the fabric needs no tristate buffers. A pad ring or bus multiplexer outside the block uses the drive flag to decide whether the RAM owns the shared data lines.

The chip responds only when two selects of opposite polarity agree: the low-true select is 0 and the high-true select is 1. A system clock samples the address, the data and the strobes. A write stores the data-in byte in the sampled cycle. A read returns the addressed byte one clock after sampling. Output drive has its own low-true enable, separate from the write strobe. An active write always turns the drive off.

Top module: `sram_dual_sel`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, dout_en is 0 and dout is 0.
- R2: The chip is enabled only when cs_n is 0 and cs_p is 1 in the same sampled cycle. An enabled cycle with we_n at 0 stores din at addr.
- R3: An enabled cycle with we_n at 1 and oe_n at 0 makes dout_en 1 after the next clock edge. In that cycle dout holds the byte stored at the sampled address.
- R4: A cycle sampled with oe_n at 1 gives dout_en 0 after the next edge, whatever the selects are.
- R5: A cycle sampled with we_n at 0 gives dout_en 0 after the next edge, even if oe_n is 0.
- R6: A write strobe in a cycle where either select is inactive leaves the array unchanged. A later read returns the earlier contents.
- R7: A cycle where either select is inactive gives dout_en 0 after the next edge.
- R8: Whenever dout_en is 0, dout is all zeros.
- R9: All 13 address bits are decoded, so no two addresses share a location. 0x0000, 0x1000 and 0x1FFF hold independent bytes.
- R10: Reads on consecutive cycles to different addresses each return their own byte, one cycle after they are sampled, with no bubble between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples all inputs |
| rst_n | input | 1 | Asynchronous low-true reset of the output registers |
| addr | input | 13 | Byte address |
| din | input | 8 | Write data |
| cs_n | input | 1 | Low-true chip select |
| cs_p | input | 1 | High-true chip select |
| we_n | input | 1 | Low-true write strobe |
| oe_n | input | 1 | Low-true output enable |
| dout | output | 8 | Read data, zero when not driving |
| dout_en | output | 1 | High when the RAM drives the data bus |

## Verification
Every result of this block appears exactly one clock edge after its inputs are sampled: the read byte, the drive flag and its forced-off cases. A write becomes visible to a read sampled on the following edge. The driver applies each access on a falling edge and queues the expected drive flag and byte for that access. The monitor pops the queue 1 ns after the next rising edge, which is the single register stage the output passes through. Back-to-back reads therefore line up one-for-one with queue entries.

// File: rtl/sram_dual_sel_pkg.sv
package sram_dual_sel_pkg;

    parameter int unsigned SRAM_ADDR_W = 13;
    parameter int unsigned SRAM_DATA_W = 8;
    localparam int unsigned SRAM_DEPTH = 1 << SRAM_ADDR_W;

    // registered output state of the RAM
    typedef struct packed {
        logic                   drive;
        logic [SRAM_DATA_W-1:0] data;
    } sram_out_t;

    localparam sram_out_t SRAM_OUT_IDLE = '{drive: 1'b0, data: '0};

endpackage

// File: rtl/sram_sel_decode.sv
module sram_sel_decode (
    input  logic cs_n,
    input  logic cs_p,
    input  logic we_n,
    input  logic oe_n,
    output logic chip_on,
    output logic wr_stb,
    output logic rd_drive
);

    always_comb begin
        // both selects must agree for the device to respond
        chip_on  = !cs_n && cs_p;
        wr_stb   = chip_on && !we_n;
        // a write strobe always wins over output enable
        rd_drive = chip_on && we_n && !oe_n;
    end

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // storage has no reset, like the physical part
    always_ff @(posedge clk) begin
        if (wr_stb) begin
            cells[addr] <= wdata;
        end
    end

    always_comb begin
        rdata = cells[addr];
    end

endmodule

// File: rtl/sram_dual_sel.sv
module sram_dual_sel
    import sram_dual_sel_pkg::*;
#(
    parameter int unsigned ADDR_W = SRAM_ADDR_W,
    parameter int unsigned DATA_W = SRAM_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              cs_n,
    input  logic              cs_p,
    input  logic              we_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    typedef struct packed {
        logic              drive;
        logic [DATA_W-1:0] data;
    } out_state_t;

    logic              chip_on;
    logic              wr_stb;
    logic              rd_drive;
    logic [DATA_W-1:0] arr_rdata;

    out_state_t out_d;
    out_state_t out_q;

    sram_sel_decode u_decode (
        .cs_n     (cs_n),
        .cs_p     (cs_p),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .chip_on  (chip_on),
        .wr_stb   (wr_stb),
        .rd_drive (rd_drive)
    );

    sram_byte_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk    (clk),
        .wr_stb (wr_stb),
        .addr   (addr),
        .wdata  (din),
        .rdata  (arr_rdata)
    );

    // next-state: drive flag and zero-filled data when not driving
    always_comb begin
        out_d       = out_q;
        out_d.drive = rd_drive;
        out_d.data  = rd_drive ? arr_rdata : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign dout    = out_q.data;
    assign dout_en = out_q.drive;

endmodule

// File: rtl/sram_dual_sel_chk.sv
module sram_dual_sel_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              cs_p,
    input logic              we_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] dout,
    input logic              dout_en
);

    // R3
    read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && cs_p && we_n && !oe_n) |=> dout_en);

    // R4
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !dout_en);

    // R5
    write_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |=> !dout_en);

    // R7
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !cs_p) |=> !dout_en);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> (dout == '0));

endmodule

bind sram_dual_sel sram_dual_sel_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sram_dual_sel_tb.sv
module sram_dual_sel_tb;

    localparam int AW = 13;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic          cs_n = 1'b1;
    logic          cs_p = 1'b0;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [DW-1:0] dout;
    logic          dout_en;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic          q_en   [$];
    logic [DW-1:0] q_data [$];
    string         q_tag  [$];

    logic [DW-1:0] model [int];

    always #2ns clk = ~clk;

    sram_dual_sel u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .din     (din),
        .cs_n    (cs_n),
        .cs_p    (cs_p),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .dout    (dout),
        .dout_en (dout_en)
    );

    task automatic compare(input logic exp_en, input logic [DW-1:0] exp_d, input string tag);
        n_vec++;
        if (dout_en !== exp_en || dout !== exp_d) begin
            n_bad++;
            $display("FAIL %s: dout_en=%0b dout=%02h expected dout_en=%0b dout=%02h",
                     tag, dout_en, dout, exp_en, exp_d);
        end
    endtask

    // one access per clock; expectation queued for the next edge
    task automatic access(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic c_n, input logic c_p,
                          input logic w_n, input logic o_n, input string tag);
        logic          sel;
        logic          en;
        logic [DW-1:0] ed;
        @(negedge clk);
        addr = a; din = d; cs_n = c_n; cs_p = c_p; we_n = w_n; oe_n = o_n;
        sel = !c_n && c_p;
        en  = sel && w_n && !o_n;
        ed  = '0;
        if (en) ed = model.exists(int'(a)) ? model[int'(a)] : 'x;
        if (sel && !w_n) model[int'(a)] = d;
        q_en.push_back(en);
        q_data.push_back(ed);
        q_tag.push_back(tag);
    endtask

    // monitor: one register stage between inputs and outputs
    initial begin
        forever begin
            @(posedge clk);
            #1ns;
            if (q_en.size() > 0) begin
                compare(q_en.pop_front(), q_data.pop_front(), q_tag.pop_front());
            end
        end
    end

    initial begin
        #(4ns * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(1'b0, '0, "R1 in reset");
        rst_n = 1'b1;
        @(posedge clk);
        #1ns;
        compare(1'b0, '0, "R1 after release");

        // R2 R9 writes, one with oe_n low for R5
        access(13'h0000, 8'h11, 0, 1, 0, 1, "R2 write low");
        access(13'h1FFF, 8'hEE, 0, 1, 0, 0, "R5 write with oe low");
        access(13'h1000, 8'h5A, 0, 1, 0, 1, "R9 write mid");
        access(13'h0ABC, 8'h3C, 0, 1, 0, 1, "R2 write");

        // R3 R10 back-to-back reads
        access(13'h0000, 8'h00, 0, 1, 1, 0, "R9 read 0x0000");
        access(13'h1FFF, 8'h00, 0, 1, 1, 0, "R10 read 0x1FFF");
        access(13'h1000, 8'h00, 0, 1, 1, 0, "R10 read 0x1000");
        access(13'h0ABC, 8'h00, 0, 1, 1, 0, "R3 read 0x0ABC");

        // R4 R8 output enable off
        access(13'h0000, 8'h00, 0, 1, 1, 1, "R4 oe high");

        // R6 writes with one select inactive
        access(13'h0000, 8'hFF, 1, 1, 0, 1, "R6 write cs_n high");
        access(13'h1FFF, 8'h00, 0, 0, 0, 0, "R6 write cs_p low");
        access(13'h0000, 8'h00, 0, 1, 1, 0, "R6 read back 0x0000");
        access(13'h1FFF, 8'h00, 0, 1, 1, 0, "R6 read back 0x1FFF");

        // R7 R8 deselected reads
        access(13'h1000, 8'h00, 0, 0, 1, 0, "R7 read cs_p low");
        access(13'h1000, 8'h00, 1, 1, 1, 0, "R7 read cs_n high");
        access(13'h1000, 8'h00, 1, 0, 1, 0, "R8 both inactive");

        // mixed traffic over written addresses
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            logic [3:0]    ctl;
            case ($urandom_range(0, 3))
                0: a = 13'h0000;
                1: a = 13'h1000;
                2: a = 13'h1FFF;
                default: a = 13'h0ABC;
            endcase
            ctl = 4'($urandom);
            access(a, 8'($urandom), ctl[0], ctl[1], ctl[2], ctl[3], "R2 R3 R4 R5 R7 mixed");
        end

        // drain
        access(13'h0000, 8'h00, 1, 0, 1, 1, "R8 final idle");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule